// File: doc/BRIEF.md
# Split-Mode External Memory Router

This block stands between a processor's data-memory port and two targets: a small on-chip RAM and an external byte-wide memory bus. Every access request is routed either to the on-chip RAM, which completes in one cycle, or to the external bus, where a short sequencer runs a read or write cycle. The routing depends on a 2-bit mode field and on a fixed 8 KB boundary. Accesses that carry only an 8-bit address get their upper address byte from a page register or from the external address-high latch, depending on the mode.

External cycles come in two forms. In the multiplexed form, the low address byte and the data share one byte-wide bus, and an address-latch strobe (ALE) marks the address phase. The high and low phases of ALE are each stretched to a programmable number of cycles. In the non-multiplexed form, the address stays on dedicated outputs for the whole cycle, ALE is never raised, and a single setup cycle comes before the strobe. The processor sees `acc_busy` for the length of an external cycle and then a one-cycle `acc_done`.

Top module: `xmem_router`

## Requirements
- R1: The page register resets to 0x00. In modes 00, 10 and 11, an 8-bit (`acc_short`) access uses the page value as the high address byte, so page N covers addresses N*256 to N*256+255.
- R2: The configuration register resets to 0x03. Its fields are bits [1:0] for ALE width, bits [3:2] for mode and bit 4 for non-multiplexed select. Bits 7:5 always read 0, and writes to them are ignored.
- R3: In mode 00, every access goes to on-chip RAM, with `ram_addr` equal to the low 13 bits of the effective address, and no external activity occurs.
- R4: In mode 11, every access goes to the external bus, and `ram_en` never rises.
- R5: In modes 01 and 10, an effective address below 0x2000 goes on-chip, and an effective address of 0x2000 or above goes off-chip.
- R6: In mode 01, an 8-bit access takes its high byte from the current address-high latch (`ext_ahi`) instead of the page register. That latch holds the high byte of the last external access and resets to 0x00.
- R7: In a multiplexed cycle, ALE is high for W+1 cycles while the bus drives the low address byte. ALE is then low for W+1 cycles, followed by one strobe cycle. W is the ALE width field. RD_n and WR_n are never low together.
- R8: In a non-multiplexed cycle, one setup cycle is followed by one strobe cycle. ALE stays low, and the ALE width field has no effect.
- R9: `acc_busy` is high from the cycle after an off-chip request is accepted through the strobe cycle. `acc_done` pulses in the cycle after the strobe. An on-chip access raises `acc_done` in the cycle after the request.
- R10: When the block is not busy, ALE is low, RD_n and WR_n are high, and `ext_ad_oe` is low.
- R11: A read samples `ext_ad_in` at the end of the strobe cycle and returns it on `acc_rdata` while `acc_done` is high. A write drives its data on `ext_ad_out` during the strobe. An on-chip read returns `ram_rdata`.
- R12: A register write and an access request in the same cycle: the access uses the register values from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration register write enable |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read value |
| page_we | input | 1 | Page register write enable |
| page_wdata | input | 8 | Page write data |
| page_rdata | output | 8 | Page read value |
| acc_req | input | 1 | Access request, taken when not busy |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_short | input | 1 | Access carries an 8-bit address only |
| acc_addr | input | 16 | Access address (low byte only when short) |
| acc_wdata | input | 8 | Write data |
| acc_busy | output | 1 | External cycle in progress |
| acc_done | output | 1 | Access complete, read data valid |
| acc_rdata | output | 8 | Read data |
| ram_en | output | 1 | On-chip RAM access strobe |
| ram_we | output | 1 | On-chip RAM write |
| ram_addr | output | 13 | On-chip RAM address |
| ram_wdata | output | 8 | On-chip RAM write data |
| ram_rdata | input | 8 | On-chip RAM read data, one cycle after `ram_en` |
| ext_ale | output | 1 | Address-latch strobe |
| ext_rd_n | output | 1 | External read strobe, active low |
| ext_wr_n | output | 1 | External write strobe, active low |
| ext_ahi | output | 8 | External address high byte (latched) |
| ext_alo | output | 8 | External address low byte (non-multiplexed form) |
| ext_ad_out | output | 8 | Shared address/data bus, driven value |
| ext_ad_oe | output | 1 | Shared bus output enable |
| ext_ad_in | input | 8 | Shared bus input value |

## Verification
Two functions can fall in the same cycle: a register write and an access request that reads that register. The bench provokes this by writing the page register in the very cycle that an 8-bit off-chip access is requested in mode 10. The access must carry the old page value on `ext_ahi`, and the new value must appear only on the next access. The same collision with the configuration register is also driven. A behavioural reference model, updated at each rising edge, predicts every strobe, the address latch and the returned data, and these are compared in every cycle.

// File: rtl/xmem_router.sv
module xmem_router #(
  parameter logic [15:0] SPLIT_BOUND = 16'h2000,
  parameter int          RAM_AW      = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              page_we,
  input  logic [7:0]        page_wdata,
  output logic [7:0]        page_rdata,
  input  logic              acc_req,
  input  logic              acc_wr,
  input  logic              acc_short,
  input  logic [15:0]       acc_addr,
  input  logic [7:0]        acc_wdata,
  output logic              acc_busy,
  output logic              acc_done,
  output logic [7:0]        acc_rdata,
  output logic              ram_en,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  input  logic [7:0]        ram_rdata,
  output logic              ext_ale,
  output logic              ext_rd_n,
  output logic              ext_wr_n,
  output logic [7:0]        ext_ahi,
  output logic [7:0]        ext_alo,
  output logic [7:0]        ext_ad_out,
  output logic              ext_ad_oe,
  input  logic [7:0]        ext_ad_in
);

  typedef enum logic [2:0] {S_IDLE, S_AHI, S_ALO, S_SETUP, S_STRB} st_t;

  st_t        st;
  logic [4:0] cfg_q;
  logic [7:0] page_q, ahi_q, alo_q, wdata_q, rdata_q;
  logic [1:0] cnt;
  logic       wr_q, ext_src_q, done_q;

  wire [1:0]  mode   = cfg_q[3:2];
  wire        nonmux = cfg_q[4];
  wire [1:0]  alew   = cfg_q[1:0];

  wire [7:0]  hi   = !acc_short ? acc_addr[15:8] :
                     (mode == 2'b01) ? ahi_q : page_q;
  wire [15:0] eff  = {hi, acc_addr[7:0]};
  wire        off  = (mode == 2'b11) || (mode != 2'b00 && eff >= SPLIT_BOUND);
  wire        take = acc_req && st == S_IDLE;
  wire        strb = st == S_STRB;

  assign cfg_rdata  = {3'b000, cfg_q};
  assign page_rdata = page_q;

  assign ram_en    = take && !off;
  assign ram_we    = ram_en && acc_wr;
  assign ram_addr  = eff[RAM_AW-1:0];
  assign ram_wdata = acc_wdata;

  assign acc_busy  = st != S_IDLE;
  assign acc_done  = done_q;
  assign acc_rdata = ext_src_q ? rdata_q : ram_rdata;

  assign ext_ale    = st == S_AHI;
  assign ext_rd_n   = !(strb && !wr_q);
  assign ext_wr_n   = !(strb && wr_q);
  assign ext_ahi    = ahi_q;
  assign ext_alo    = alo_q;
  assign ext_ad_oe  = ext_ale || (strb && wr_q);
  assign ext_ad_out = ext_ale ? alo_q : wdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cfg_q     <= 5'b00011;
      page_q    <= 8'h00;
      ahi_q     <= 8'h00;
      alo_q     <= 8'h00;
      wdata_q   <= 8'h00;
      rdata_q   <= 8'h00;
      cnt       <= 2'd0;
      wr_q      <= 1'b0;
      ext_src_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (cfg_we)  cfg_q  <= cfg_wdata[4:0];
      if (page_we) page_q <= page_wdata;
      case (st)
        S_IDLE: if (take) begin
          ext_src_q <= off;
          if (!off) begin
            done_q <= 1'b1;
          end else begin
            ahi_q   <= hi;
            alo_q   <= acc_addr[7:0];
            wr_q    <= acc_wr;
            wdata_q <= acc_wdata;
            cnt     <= alew;
            st      <= nonmux ? S_SETUP : S_AHI;
          end
        end
        S_AHI: if (cnt == 2'd0) begin
          st  <= S_ALO;
          cnt <= alew;
        end else cnt <= cnt - 2'd1;
        S_ALO: if (cnt == 2'd0) st <= S_STRB;
               else cnt <= cnt - 2'd1;
        S_SETUP: st <= S_STRB;
        S_STRB: begin
          st     <= S_IDLE;
          done_q <= 1'b1;
          if (!wr_q) rdata_q <= ext_ad_in;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

module xmem_router_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] cfg_rdata,
  input logic       acc_busy,
  input logic       acc_done,
  input logic       ram_en,
  input logic       ext_ale,
  input logic       ext_rd_n,
  input logic       ext_wr_n,
  input logic       ext_ad_oe
);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_busy |-> (!ext_ale && ext_rd_n && ext_wr_n && !ext_ad_oe));

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ext_rd_n && !ext_wr_n));

  // R9
  strobe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_rd_n || !ext_wr_n) |-> acc_busy);

  // R9
  strobe_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_rd_n || !ext_wr_n) |=> (!acc_busy && acc_done));

  // R2
  cfg_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[7:5] == 3'b000);

  // R7
  ale_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ext_ale) |-> (ext_rd_n && ext_wr_n));

  // R3
  ram_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_en |-> !acc_busy);

  // R8
  nonmux_noale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[4] && !acc_busy) |=> !ext_ale);

endmodule

bind xmem_router xmem_router_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_rdata(cfg_rdata), .acc_busy(acc_busy),
  .acc_done(acc_done), .ram_en(ram_en), .ext_ale(ext_ale),
  .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n), .ext_ad_oe(ext_ad_oe)
);

// File: tb/sim_xmem_router.sv
`timescale 1ns/1ps
module sim_xmem_router;
  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic cfg_we = 0, page_we = 0, acc_req = 0, acc_wr = 0, acc_short = 0;
  logic [7:0] cfg_wdata = 0, page_wdata = 0, acc_wdata = 0;
  logic [15:0] acc_addr = 0;
  logic [7:0] cfg_rdata, page_rdata, acc_rdata, ram_wdata, ext_ahi, ext_alo, ext_ad_out;
  logic acc_busy, acc_done, ram_en, ram_we, ext_ale, ext_rd_n, ext_wr_n, ext_ad_oe;
  logic [12:0] ram_addr;
  logic [7:0] ram_rdata = 8'hC3;
  logic [7:0] ext_ad_in = 8'h00;

  xmem_router u0 (.*);

  int total = 0, bad = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) ext_ad_in <= ext_ad_in + 8'd37;

  // behavioural reference model
  logic [4:0] m_cfg;
  logic [7:0] m_page, m_ahi, m_alo, m_wd, m_rd;
  logic m_wr, m_ext, m_done;
  int ph, left;

  function automatic logic [15:0] m_eff(input logic s, input logic [15:0] a);
    if (!s) return a;
    if (m_cfg[3:2] == 2'b01) return {m_ahi, a[7:0]};
    return {m_page, a[7:0]};
  endfunction

  function automatic bit m_off(input logic s, input logic [15:0] a);
    int e;
    e = int'(m_eff(s, a));
    case (m_cfg[3:2])
      2'b00: return 0;
      2'b11: return 1;
      default: return e >= 8192;
    endcase
  endfunction

  always @(posedge clk) begin
    logic [15:0] e;
    bit nd;
    if (!rst_n) begin
      m_cfg = 5'h03; m_page = 0; m_ahi = 0; m_alo = 0; m_wd = 0; m_rd = 0;
      m_wr = 0; m_ext = 0; m_done = 0; ph = 0; left = 0;
    end else begin
      nd = 0;
      if (ph == 0) begin
        if (acc_req) begin
          e = m_eff(acc_short, acc_addr);
          m_ext = m_off(acc_short, acc_addr);
          if (!m_ext) nd = 1;
          else begin
            m_ahi = e[15:8]; m_alo = e[7:0]; m_wr = acc_wr; m_wd = acc_wdata;
            if (m_cfg[4]) ph = 4;
            else begin ph = 1; left = int'(m_cfg[1:0]) + 1; end
          end
        end
      end else if (ph == 1) begin
        left--;
        if (left == 0) begin ph = 2; left = int'(m_cfg[1:0]) + 1; end
      end else if (ph == 2) begin
        left--;
        if (left == 0) ph = 3;
      end else if (ph == 4) ph = 3;
      else begin
        ph = 0; nd = 1;
        if (!m_wr) m_rd = ext_ad_in;
      end
      m_done = nd;
      if (cfg_we) m_cfg = cfg_wdata[4:0];
      if (page_we) m_page = page_wdata;
    end
  end

  always @(posedge clk) begin
    #5;
    if (rst_n) begin
      logic exp_oe, exp_ram;
      logic [15:0] e;
      exp_oe  = (ph == 1) || (ph == 3 && m_wr);
      exp_ram = (ph == 0) && acc_req && !m_off(acc_short, acc_addr);
      e = m_eff(acc_short, acc_addr);
      chk(ext_ale == (ph == 1), "R7/R8 ale", ext_ale, ph == 1);
      chk(ext_rd_n == !(ph == 3 && !m_wr), "R7 rd_n", ext_rd_n, !(ph == 3 && !m_wr));
      chk(ext_wr_n == !(ph == 3 && m_wr), "R7 wr_n", ext_wr_n, !(ph == 3 && m_wr));
      chk(acc_busy == (ph != 0), "R9 busy", acc_busy, ph != 0);
      chk(ext_ad_oe == exp_oe, "R10 bus_oe", ext_ad_oe, exp_oe);
      if (exp_oe)
        chk(ext_ad_out == (ph == 1 ? m_alo : m_wd), "R11 bus_out", ext_ad_out,
            ph == 1 ? m_alo : m_wd);
      chk(ram_en == exp_ram, "R3/R4/R5 ram_en", ram_en, exp_ram);
      if (exp_ram) begin
        chk(ram_addr == e[12:0], "R3 ram_addr", ram_addr, e[12:0]);
        chk(ram_we == acc_wr, "R3 ram_we", ram_we, acc_wr);
      end
      chk(ext_ahi == m_ahi, "R1/R6 ahi", ext_ahi, m_ahi);
      chk(ext_alo == m_alo, "R8 alo", ext_alo, m_alo);
      chk(acc_done == m_done, "R9 done", acc_done, m_done);
      if (m_done && !m_wr)
        chk(acc_rdata == (m_ext ? m_rd : 8'hC3), "R11 rdata", acc_rdata,
            m_ext ? m_rd : 8'hC3);
      chk(cfg_rdata == {3'b000, m_cfg}, "R2 cfg_rdata", cfg_rdata, {3'b000, m_cfg});
      chk(page_rdata == m_page, "R1 page_rdata", page_rdata, m_page);
    end
  end

  task automatic wcfg(input logic [7:0] v);
    @(negedge clk); cfg_we = 1; cfg_wdata = v;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic wpage(input logic [7:0] v);
    @(negedge clk); page_we = 1; page_wdata = v;
    @(negedge clk); page_we = 0;
  endtask

  task automatic acc(input logic wr, input logic s, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    acc_req = 1; acc_wr = wr; acc_short = s; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_req = 0; page_we = 0; cfg_we = 0;
    while (acc_busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cfg_rdata == 8'h03, "R2 reset cfg", cfg_rdata, 8'h03);
    chk(page_rdata == 8'h00, "R1 reset page", page_rdata, 8'h00);
    chk(ext_ale == 0 && ext_rd_n && ext_wr_n && !ext_ad_oe, "R10 reset idle", ext_ad_oe, 0);

    // R3 mode 00: alias on-chip
    acc(0, 0, 16'h8123, 8'h00);
    acc(1, 1, 16'h00FE, 8'h5A);
    chk(ext_ahi == 8'h00, "R3 no ext activity", ext_ahi, 8'h00);

    // R2 top bits ignored
    wcfg(8'hFF);
    chk(cfg_rdata == 8'h1F, "R2 top bits", cfg_rdata, 8'h1F);
    // R4/R8 mode 11 non-multiplexed, width field ignored
    acc(1, 0, 16'h0010, 8'hA5);
    acc(0, 0, 16'h3344, 8'h00);
    chk(ext_ahi == 8'h33 && ext_alo == 8'h44, "R8 addr lines", {ext_ahi, ext_alo}, 16'h3344);

    // R7 mode 11 multiplexed, each width
    for (int w = 0; w < 4; w++) begin
      wcfg(8'h0C | 8'(w));
      acc(0, 0, 16'h0005, 8'h00);
      acc(1, 0, 16'hFF00 | 16'(w), 8'h11 * 8'(w + 1));
    end

    // R5 mode 10 split, boundary
    wcfg(8'h0A);
    acc(0, 0, 16'h1FFF, 8'h00);
    acc(1, 0, 16'h2000, 8'h77);
    chk(ext_ahi == 8'h20, "R5 boundary off-chip", ext_ahi, 8'h20);
    wpage(8'h40);
    acc(0, 1, 16'h0012, 8'h00);
    chk(ext_ahi == 8'h40, "R1 page high byte", ext_ahi, 8'h40);
    wpage(8'h10);
    acc(0, 1, 16'h0034, 8'h00);
    chk(ext_ahi == 8'h40, "R5 page below bound on-chip", ext_ahi, 8'h40);

    // R12 page write collides with short access
    wpage(8'h40);
    @(negedge clk);
    page_we = 1; page_wdata = 8'h80;
    acc_req = 1; acc_wr = 0; acc_short = 1; acc_addr = 16'h0099;
    @(negedge clk);
    acc_req = 0; page_we = 0;
    while (acc_busy) @(negedge clk);
    chk(ext_ahi == 8'h40, "R12 old page used", ext_ahi, 8'h40);
    acc(0, 1, 16'h0001, 8'h00);
    chk(ext_ahi == 8'h80, "R12 new page next", ext_ahi, 8'h80);

    // R12 cfg write collides with access (old mode 10 multiplexed applies)
    @(negedge clk);
    cfg_we = 1; cfg_wdata = 8'h1C;
    acc_req = 1; acc_wr = 1; acc_short = 0; acc_addr = 16'h4455; acc_wdata = 8'h3C;
    @(negedge clk);
    acc_req = 0; cfg_we = 0;
    chk(ext_ale == 1, "R12 old cfg multiplexed", ext_ale, 1);
    while (acc_busy) @(negedge clk);
    @(negedge clk);

    // R6 mode 01: short uses address-high latch
    wcfg(8'h05);
    wpage(8'hC0);
    acc(0, 0, 16'h4400, 8'h00);
    acc(0, 1, 16'h0033, 8'h00);
    chk(ext_ahi == 8'h44, "R6 latch high byte", ext_ahi, 8'h44);
    acc(1, 0, 16'h0100, 8'h66);
    acc(0, 0, 16'h7700, 8'h00);
    acc(1, 1, 16'h00AB, 8'hE1);
    chk(ext_ahi == 8'h77, "R6 latch follows last", ext_ahi, 8'h77);

    // mode 00 short alias
    wcfg(8'h00);
    acc(0, 1, 16'h0021, 8'h00);

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule